// File: doc/BRIEF.md
# Dual-Address Coalescing Register Bank

One bank of a wide register file. Each row holds a full vector register of 32 lanes of 32 bits, spread over eight 128-bit sub-banks. Each lane word is split into a left half (bits 31:16) and a right half (bits 15:0). A narrow value is placed in one of these two halves. On the way into storage the bank regroups the bits. The left halves of all lanes go to the upper four sub-banks and the right halves to the lower four.

Each sub-bank has its own row-address multiplexer. A read request carries two operands, each with a row address and a half flag. When one operand wants the left half and the other wants the right half, the upper sub-banks are driven with one row and the lower sub-banks with another, so both come out of a single access. When both operands want the same half of different rows, the bank splits the request over two accesses. It raises `busy` for the cycle in between and ignores new requests during that cycle. A single-operand read gives the same row to both operands, one per half, and gets the whole register back.

Read data is registered. Each returned operand is 32 lanes wide, with every lane holding the selected half zero-extended.

Top module: `dual_addr_rf_bank`

## Requirements
- R1: After reset, `rd_valid` and `busy` are low and both operand outputs are all zeros.
- R2: Write data and operand outputs use lane layout: lane i occupies bits [32i+31:32i]. A write stores the whole row. A read that names the same row for both operands, one with the left flag set and one with it clear, returns that row's halves with `rd_valid` high in the following cycle.
- R3: In every returned operand, lane i bits [32i+15:32i] carry the selected half (left = stored bits [32i+31:32i+16], right = stored bits [32i+15:32i]) and bits [32i+31:32i+16] are zero.
- R4: A request whose two operands select different halves is served in one access, even for different rows. `rd_valid` is high one cycle later and `busy` stays low.
- R5: A request whose two operands select the same half of different rows raises `busy` for exactly the next cycle. `rd_valid` is low in that cycle and high in the cycle after, with both operands correct.
- R6: A request presented while `busy` is high is ignored. It produces no `rd_valid` and does not alter the pending result.
- R7: Two operands that select the same half of the same row are served in one access and return identical data.
- R8: A read and a write to the same row in the same cycle return the row's old contents; a later read returns the new contents.
- R9: In any cycle with `rd_valid` low, both operand outputs are all zeros.
- R10: Non-splitting requests on consecutive cycles each return valid data in the following cycle, one result per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | $clog2(DEPTH) | Row to write |
| wr_data | input | 1024 | Row data in lane layout |
| rd_req | input | 1 | Read request |
| rd_a_addr | input | $clog2(DEPTH) | Row of operand A |
| rd_a_left | input | 1 | Operand A takes the left half (1) or right half (0) |
| rd_b_addr | input | $clog2(DEPTH) | Row of operand B |
| rd_b_left | input | 1 | Operand B takes the left half (1) or right half (0) |
| busy | output | 1 | Second access of a split request; new requests ignored |
| rd_valid | output | 1 | Operand outputs hold a result |
| op_a | output | 1024 | Operand A, each lane zero-extended |
| op_b | output | 1024 | Operand B, each lane zero-extended |

## Verification
The bench builds the bank with its default parameters: 16 rows and eight 128-bit sub-banks forming a 1024-bit row of 32 lanes. With these values every row, including row 0 and row 15, can be filled with a distinct pattern. Each lane carries different left and right halves, so a swapped half, a misrouted sub-bank address or a missing zero-extension shows up in the data. The small row count also keeps both the split and the single-access paths reachable with reads that pair extreme rows.

// File: rtl/drf_pkg.sv
package drf_pkg;
    localparam int unsigned DRF_DEPTH   = 16;
    localparam int unsigned DRF_NUM_SUB = 8;
    localparam int unsigned DRF_SUB_W   = 128;
    localparam int unsigned DRF_LANE_W  = 32;

    typedef enum logic {
        ST_READY  = 1'b0,
        ST_SECOND = 1'b1
    } drf_state_e;
endpackage

// File: rtl/drf_subbank.sv
module drf_subbank #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 128,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Read sees the value before this cycle's write.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/drf_swizzle.sv
module drf_swizzle #(
    parameter int unsigned ROW_W  = 1024,
    parameter int unsigned LANE_W = 32,
    localparam int unsigned LANES = ROW_W / LANE_W,
    localparam int unsigned HALF  = LANE_W / 2,
    localparam int unsigned HB    = ROW_W / 2
) (
    input  logic [ROW_W-1:0] lanes,
    output logic [ROW_W-1:0] phys
);
    // Left halves gather in the upper sub-banks, right halves in the lower.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign phys[HB + i*HALF +: HALF] = lanes[i*LANE_W + HALF +: HALF];
        assign phys[i*HALF +: HALF]      = lanes[i*LANE_W +: HALF];
    end
endmodule

// File: rtl/drf_unpack.sv
module drf_unpack #(
    parameter int unsigned ROW_W  = 1024,
    parameter int unsigned LANE_W = 32,
    localparam int unsigned LANES = ROW_W / LANE_W,
    localparam int unsigned HALF  = LANE_W / 2,
    localparam int unsigned HB    = ROW_W / 2
) (
    input  logic [ROW_W-1:0] phys,
    input  logic             take_left,
    output logic [ROW_W-1:0] lanes
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lanes[i*LANE_W +: LANE_W] = {{HALF{1'b0}},
            take_left ? phys[HB + i*HALF +: HALF] : phys[i*HALF +: HALF]};
    end
endmodule

// File: rtl/drf_ctrl.sv
module drf_ctrl
    import drf_pkg::*;
#(
    parameter int unsigned AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [AW-1:0] a_addr,
    input  logic          a_left,
    input  logic [AW-1:0] b_addr,
    input  logic          b_left,
    output logic [AW-1:0] addr_hi,
    output logic [AW-1:0] addr_lo,
    output logic          rd_en,
    output logic          cap_a,
    output logic          busy,
    output logic          vld_q,
    output logic          a_left_q,
    output logic          b_left_q,
    output logic          hold_sel_q
);
    drf_state_e    state, nxt;
    logic [AW-1:0] b_addr_q;
    logic          split;
    logic          take;

    assign split = (a_left == b_left) && (a_addr != b_addr);
    assign take  = (state == ST_READY) && rd_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_READY;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt     = state;
        addr_hi = a_addr;
        addr_lo = a_addr;
        rd_en   = 1'b0;
        cap_a   = 1'b0;
        busy    = 1'b0;
        unique case (state)
            ST_READY: begin
                if (rd_req) begin
                    rd_en = 1'b1;
                    if (split) begin
                        nxt = ST_SECOND;
                    end else begin
                        addr_hi = a_left ? a_addr : b_addr;
                        addr_lo = a_left ? b_addr : a_addr;
                    end
                end
            end
            ST_SECOND: begin
                rd_en   = 1'b1;
                cap_a   = 1'b1;
                busy    = 1'b1;
                addr_hi = b_addr_q;
                addr_lo = b_addr_q;
                nxt     = ST_READY;
            end
            default: nxt = ST_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q      <= 1'b0;
            a_left_q   <= 1'b0;
            b_left_q   <= 1'b0;
            hold_sel_q <= 1'b0;
            b_addr_q   <= '0;
        end else begin
            vld_q <= (take && !split) || (state == ST_SECOND);
            if (take) begin
                a_left_q   <= a_left;
                b_left_q   <= b_left;
                b_addr_q   <= b_addr;
                hold_sel_q <= split;
            end
        end
    end
endmodule

// File: rtl/dual_addr_rf_bank.sv
module dual_addr_rf_bank
    import drf_pkg::*;
#(
    parameter int unsigned DEPTH   = DRF_DEPTH,
    parameter int unsigned NUM_SUB = DRF_NUM_SUB,
    parameter int unsigned SUB_W   = DRF_SUB_W,
    parameter int unsigned LANE_W  = DRF_LANE_W,
    localparam int unsigned AW     = $clog2(DEPTH),
    localparam int unsigned ROW_W  = NUM_SUB * SUB_W,
    localparam int unsigned HI_SUB = NUM_SUB / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [ROW_W-1:0] wr_data,
    input  logic             rd_req,
    input  logic [AW-1:0]    rd_a_addr,
    input  logic             rd_a_left,
    input  logic [AW-1:0]    rd_b_addr,
    input  logic             rd_b_left,
    output logic             busy,
    output logic             rd_valid,
    output logic [ROW_W-1:0] op_a,
    output logic [ROW_W-1:0] op_b
);
    logic [AW-1:0]    addr_hi, addr_lo;
    logic             rd_en, cap_a, vld_q, a_left_q, b_left_q, hold_sel_q;
    logic [ROW_W-1:0] wr_phys, rd_phys, a_raw, b_raw, hold_a;

    drf_ctrl #(.AW(AW)) ctrl_i (
        .clk, .rst_n, .rd_req,
        .a_addr(rd_a_addr), .a_left(rd_a_left),
        .b_addr(rd_b_addr), .b_left(rd_b_left),
        .addr_hi, .addr_lo, .rd_en, .cap_a, .busy,
        .vld_q, .a_left_q, .b_left_q, .hold_sel_q
    );

    drf_swizzle #(.ROW_W(ROW_W), .LANE_W(LANE_W)) swz_i (
        .lanes(wr_data), .phys(wr_phys)
    );

    for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
        logic [AW-1:0] sel_addr;
        if (s >= HI_SUB) begin : g_left
            assign sel_addr = addr_hi;
        end else begin : g_right
            assign sel_addr = addr_lo;
        end
        drf_subbank #(.DEPTH(DEPTH), .WIDTH(SUB_W)) sb_i (
            .clk,
            .we(wr_en), .waddr(wr_addr), .wdata(wr_phys[s*SUB_W +: SUB_W]),
            .re(rd_en), .raddr(sel_addr), .rdata(rd_phys[s*SUB_W +: SUB_W])
        );
    end

    drf_unpack #(.ROW_W(ROW_W), .LANE_W(LANE_W)) unp_a_i (
        .phys(rd_phys), .take_left(a_left_q), .lanes(a_raw)
    );
    drf_unpack #(.ROW_W(ROW_W), .LANE_W(LANE_W)) unp_b_i (
        .phys(rd_phys), .take_left(b_left_q), .lanes(b_raw)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_a <= '0;
        end else if (cap_a) begin
            hold_a <= a_raw;
        end
    end

    assign rd_valid = vld_q;
    assign op_a     = vld_q ? (hold_sel_q ? hold_a : a_raw) : '0;
    assign op_b     = vld_q ? b_raw : '0;
endmodule

// File: rtl/dual_addr_rf_bank_chk.sv
module dual_addr_rf_bank_chk #(
    parameter int unsigned AW     = 4,
    parameter int unsigned ROW_W  = 1024,
    parameter int unsigned LANE_W = 32,
    localparam int unsigned LANES = ROW_W / LANE_W,
    localparam int unsigned HALF  = LANE_W / 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_req,
    input logic [AW-1:0]    rd_a_addr,
    input logic             rd_a_left,
    input logic [AW-1:0]    rd_b_addr,
    input logic             rd_b_left,
    input logic             busy,
    input logic             rd_valid,
    input logic [ROW_W-1:0] op_a,
    input logic [ROW_W-1:0] op_b
);
    logic same_half_diff_row;
    assign same_half_diff_row = (rd_a_left == rd_b_left) && (rd_a_addr != rd_b_addr);

    p_split_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !busy && same_half_diff_row) |=> (busy && !rd_valid));

    p_busy_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy && rd_valid));

    p_one_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !busy && !same_half_diff_row) |=> (rd_valid && !busy));

    p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req && !busy) |=> !rd_valid);

    p_quiet_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (op_a == '0 && op_b == '0));

    for (genvar i = 0; i < LANES; i++) begin : g_ext
        p_zero_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
            rd_valid |-> (op_a[i*LANE_W + HALF +: HALF] == '0 &&
                          op_b[i*LANE_W + HALF +: HALF] == '0));
    end
endmodule

bind dual_addr_rf_bank dual_addr_rf_bank_chk #(
    .AW(AW), .ROW_W(ROW_W), .LANE_W(LANE_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req),
    .rd_a_addr(rd_a_addr), .rd_a_left(rd_a_left),
    .rd_b_addr(rd_b_addr), .rd_b_left(rd_b_left),
    .busy(busy), .rd_valid(rd_valid), .op_a(op_a), .op_b(op_b)
);

// File: tb/dual_addr_rf_bank_tb_top.sv
module dual_addr_rf_bank_tb_top;
    localparam int  CLK_PERIOD = 10;
    localparam int  DEPTH  = 16;
    localparam int  AW     = 4;
    localparam int  ROW_W  = 1024;
    localparam int  LANE_W = 32;
    localparam int  LANES  = ROW_W / LANE_W;

    typedef struct packed {
        logic [3:0] a;
        logic       al;
        logic [3:0] b;
        logic       bl;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{4'd1,  1'b1, 4'd1,  1'b0},
        '{4'd2,  1'b1, 4'd5,  1'b0},
        '{4'd7,  1'b0, 4'd3,  1'b1},
        '{4'd4,  1'b1, 4'd9,  1'b1},
        '{4'd6,  1'b0, 4'd0,  1'b0},
        '{4'd8,  1'b1, 4'd8,  1'b1},
        '{4'd15, 1'b0, 4'd15, 1'b0},
        '{4'd0,  1'b1, 4'd15, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [AW-1:0]    wr_addr = '0;
    logic [ROW_W-1:0] wr_data = '0;
    logic             rd_req = 1'b0;
    logic [AW-1:0]    rd_a_addr = '0, rd_b_addr = '0;
    logic             rd_a_left = 1'b0, rd_b_left = 1'b0;
    logic             busy, rd_valid;
    logic [ROW_W-1:0] op_a, op_b;

    logic [ROW_W-1:0] model [DEPTH];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_addr_rf_bank dut_i (
        .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
        .rd_req, .rd_a_addr, .rd_a_left, .rd_b_addr, .rd_b_left,
        .busy, .rd_valid, .op_a, .op_b
    );

    function automatic logic [ROW_W-1:0] mk_row(int r, int salt);
        logic [ROW_W-1:0] v;
        for (int i = 0; i < LANES; i++) begin
            v[i*LANE_W +: LANE_W] = {8'(r + 1 + salt), 8'(i), 8'(~r ^ salt), 8'(i*3 + 1)};
        end
        return v;
    endfunction

    function automatic logic [ROW_W-1:0] exp_op(logic [ROW_W-1:0] row, logic left);
        logic [ROW_W-1:0] v;
        for (int i = 0; i < LANES; i++) begin
            v[i*LANE_W +: LANE_W] = {16'h0, left ? row[i*LANE_W + 16 +: 16] : row[i*LANE_W +: 16]};
        end
        return v;
    endfunction

    task automatic chk_vec(string req, logic [ROW_W-1:0] act, logic [ROW_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_write(int r, logic [ROW_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(r); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model[r] = d;
    endtask

    task automatic do_read(vec_t v, string req);
        logic             split;
        logic [ROW_W-1:0] ea, eb;
        split = (v.al == v.bl) && (v.a != v.b);
        ea = exp_op(model[v.a], v.al);
        eb = exp_op(model[v.b], v.bl);
        @(negedge clk);
        rd_req = 1'b1; rd_a_addr = v.a; rd_a_left = v.al; rd_b_addr = v.b; rd_b_left = v.bl;
        @(negedge clk);
        rd_req = 1'b0;
        if (split) begin
            chk_bit("R5 busy in gap", busy, 1'b1);
            chk_bit("R5 valid low in gap", rd_valid, 1'b0);
            @(negedge clk);
        end else begin
            chk_bit({req, " busy stays low"}, busy, 1'b0);
        end
        chk_bit({req, " valid"}, rd_valid, 1'b1);
        chk_vec({req, " op_a"}, op_a, ea);
        chk_vec({req, " op_b"}, op_b, eb);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [ROW_W-1:0] old3, new3;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_bit("R1 valid", rd_valid, 1'b0);
        chk_bit("R1 busy", busy, 1'b0);
        chk_vec("R1 op_a", op_a, '0);
        chk_vec("R1 op_b", op_b, '0);
        rst_n = 1'b1;

        for (int r = 0; r < DEPTH; r++) begin
            do_write(r, mk_row(r, 0));
        end

        // Table walk: R2 (same row both halves), R4 (cross-row halves),
        // R5 (same half split), R7 (same half same row)
        for (int k = 0; k < NVEC; k++) begin
            vec_t v;
            string tag;
            v = VEC[k];
            if (v.a == v.b && v.al != v.bl)      tag = "R2";
            else if (v.al != v.bl)               tag = "R4";
            else if (v.a != v.b)                 tag = "R5";
            else                                 tag = "R7";
            do_read(v, tag);
            if (tag == "R7") chk_vec("R7 identical", op_a, op_b);
            if (tag == "R2") chk_vec("R3 zero-ext", op_a & {LANES{32'hFFFF0000}}, '0);
        end

        // R6: request during busy is ignored
        @(negedge clk);
        rd_req = 1'b1; rd_a_addr = 4'd4; rd_a_left = 1'b1; rd_b_addr = 4'd9; rd_b_left = 1'b1;
        @(negedge clk);
        chk_bit("R6 busy", busy, 1'b1);
        rd_a_addr = 4'd1; rd_a_left = 1'b1; rd_b_addr = 4'd2; rd_b_left = 1'b0;
        @(negedge clk);
        rd_req = 1'b0;
        chk_bit("R6 valid", rd_valid, 1'b1);
        chk_vec("R6 op_a kept", op_a, exp_op(model[4], 1'b1));
        chk_vec("R6 op_b kept", op_b, exp_op(model[9], 1'b1));
        @(negedge clk);
        chk_bit("R6 no extra valid", rd_valid, 1'b0);

        // R8: read and write same row same cycle
        old3 = model[3];
        new3 = mk_row(3, 77);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd3; wr_data = new3;
        rd_req = 1'b1; rd_a_addr = 4'd3; rd_a_left = 1'b1; rd_b_addr = 4'd3; rd_b_left = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; rd_req = 1'b0;
        model[3] = new3;
        chk_vec("R8 old left", op_a, exp_op(old3, 1'b1));
        chk_vec("R8 old right", op_b, exp_op(old3, 1'b0));
        do_read('{4'd3, 1'b1, 4'd3, 1'b0}, "R8 new");

        // R10: back-to-back single-access requests
        @(negedge clk);
        rd_req = 1'b1; rd_a_addr = 4'd2; rd_a_left = 1'b1; rd_b_addr = 4'd6; rd_b_left = 1'b0;
        @(negedge clk);
        chk_bit("R10 first valid", rd_valid, 1'b1);
        chk_vec("R10 first op_a", op_a, exp_op(model[2], 1'b1));
        chk_vec("R10 first op_b", op_b, exp_op(model[6], 1'b0));
        rd_a_addr = 4'd6; rd_a_left = 1'b1; rd_b_addr = 4'd2; rd_b_left = 1'b0;
        @(negedge clk);
        rd_req = 1'b0;
        chk_bit("R10 second valid", rd_valid, 1'b1);
        chk_vec("R10 second op_a", op_a, exp_op(model[6], 1'b1));
        chk_vec("R10 second op_b", op_b, exp_op(model[2], 1'b0));

        // R9: outputs zero when idle
        @(negedge clk);
        chk_bit("R9 valid low", rd_valid, 1'b0);
        chk_vec("R9 op_a zero", op_a, '0);
        chk_vec("R9 op_b zero", op_b, '0);

        done = 1'b1;
        finish_run();
    end
endmodule